// File: doc/BRIEF.md
# Calendar Clock with Frozen Readout Registers

This block keeps the time of day and the calendar in binary-coded decimal: seconds, minutes, hours, day of month, month, two-digit year and century. A prescaler counts enable pulses from a 32.768 kHz source and produces one tick per second. Each tick advances a private set of running counters. A second set of registers, the only one software can see, normally takes the new time on every tick.

Software reaches the block through a 16-byte window that behaves like an asynchronous static RAM, sampled in the system clock domain. A control byte holds two bits. The freeze bit stops the visible registers from following the running counters, so that a multi-byte read is consistent. The freeze costs no accuracy, because the running counters keep advancing. If software writes new time bytes while frozen, clearing the freeze loads them into the running counters and restarts the prescaler. If nothing was written, clearing the freeze only lets the visible registers catch up at the next tick.

The keep-alive bit decides whether the clock keeps counting while the supply-fail input is high. A supply failure also blocks every bus write, and the write lock stays on for a programmable recovery time after the supply comes back.

Top module: `rtc_shadow_regs`

## Requirements
- R1: After reset the visible time reads 00:00:00 on day 01, month 01, year 00, century 20, and the control byte at address 0xE reads 0x00.
- R2: The running counters advance by one second on every PRESCALE_DIV-th cycle with osc_en high. When the freeze bit is clear, the visible registers show the new time from the cycle in which the counters advance.
- R3: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00, each carrying into the next field. Years wrap from 99 to 00 and add one to the century. A BCD low digit of 9 carries into the tens digit.
- R4: The day wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. In month 02 it wraps after 29 when the year value is a multiple of 4, and after 28 otherwise. Every wrap of the day advances the month, and month 12 wraps to 01.
- R5: Bit 3 of the control byte is the freeze bit. While it is 1, the visible registers keep their values across ticks, and the running counters keep advancing.
- R6: A write that sets the freeze bit in the same cycle as a tick does not cancel that tick's refresh. The visible registers show the advanced time and then stay frozen.
- R7: Clearing the freeze bit when no time byte was written during the freeze does not change the running counters or the visible registers. The visible registers take the running time at the next tick.
- R8: Clearing the freeze bit after one or more time bytes were written during the freeze copies the visible bytes into the running counters and restarts the prescaler. The next tick comes a full PRESCALE_DIV osc_en cycles later.
- R9: The time bytes sit at addresses 0x0 to 0x6, in the order seconds, minutes, hours, day, month, year, century. A write to them is ignored while the freeze bit is 0.
- R10: rdata_oe is 1 and rdata carries the addressed byte only while cs_n and oe_n are low and we_n is high; otherwise rdata reads 0x00. Addresses 0x7 to 0xD and 0xF read 0x00. The control byte reads the keep-alive bit at bit 7 and the freeze bit at bit 3.
- R11: A write takes the address and data of the last cycle in which cs_n and we_n were both low. It takes effect when the first of the two strobes rises.
- R12: Bit 7 of the control byte is the keep-alive bit. While pwr_fail is high, ticks occur only if the keep-alive bit is 1. While pwr_fail is low, ticks occur regardless of it.
- R13: While pwr_fail is high, all writes are discarded. They stay discarded for RECOVER_CYCLES clock cycles after pwr_fail falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | One pulse per 32.768 kHz oscillator period |
| pwr_fail | input | 1 | Main supply below threshold (battery mode) |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 4 | Byte address in the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when not driven |
| rdata_oe | output | 1 | High while the block drives rdata |

## Verification
The freeze write and the once-per-second refresh can land on the same clock edge. That is the case where a careless design would either lose the refresh or keep refreshing after the freeze. The bench restarts the prescaler with a time-setting transfer, then counts cycles so that the commit edge of the freeze write falls exactly on the next tick. It judges the result by reading back the advanced second. It then waits several more ticks to confirm that the visible registers stay frozen, releases the freeze, and checks that they catch up with the running count at the following tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_SEC  = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_CEN  = 4'h6;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'hE;

  localparam int CTRL_FREEZE_BIT = 3;
  localparam int CTRL_KEEP_BIT   = 7;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_AT_RESET = '{cen: 8'h20, yr: 8'h00, mon: 8'h01,
                                          day: 8'h01, hr: 8'h00, min: 8'h00,
                                          sec: 8'h00};

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_value(input logic [7:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr_bcd);
    logic [7:0] b;
    b = bcd_value(yr_bcd);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon,
                                           input logic [7:0] yr);
    case (mon)
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t advance_second(input rtc_time_t t);
    rtc_time_t r;
    r = t;
    if (t.sec != 8'h59) begin
      r.sec = bcd_step(t.sec);
    end else begin
      r.sec = 8'h00;
      if (t.min != 8'h59) begin
        r.min = bcd_step(t.min);
      end else begin
        r.min = 8'h00;
        if (t.hr != 8'h23) begin
          r.hr = bcd_step(t.hr);
        end else begin
          r.hr = 8'h00;
          if (t.day != month_end(t.mon, t.yr)) begin
            r.day = bcd_step(t.day);
          end else begin
            r.day = 8'h01;
            if (t.mon != 8'h12) begin
              r.mon = bcd_step(t.mon);
            end else begin
              r.mon = 8'h01;
              if (t.yr != 8'h99) begin
                r.yr = bcd_step(t.yr);
              end else begin
                r.yr  = 8'h00;
                r.cen = (t.cen == 8'h99) ? 8'h00 : bcd_step(t.cen);
              end
            end
          end
        end
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] field_get(input rtc_time_t t,
                                           input logic [ADDR_W-1:0] a);
    case (a)
      4'h0:    return t.sec;
      4'h1:    return t.min;
      4'h2:    return t.hr;
      4'h3:    return t.day;
      4'h4:    return t.mon;
      4'h5:    return t.yr;
      4'h6:    return t.cen;
      default: return 8'h00;
    endcase
  endfunction

  function automatic rtc_time_t field_put(input rtc_time_t t,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [7:0] v);
    rtc_time_t r;
    r = t;
    case (a)
      4'h0:    r.sec = v;
      4'h1:    r.min = v;
      4'h2:    r.hr  = v;
      4'h3:    r.day = v;
      4'h4:    r.mon = v;
      4'h5:    r.yr  = v;
      4'h6:    r.cen = v;
      default: r = t;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  generate
    if (DIV == 1) begin : g_direct
      assign tick = run && osc_en && !restart;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign tick = run && osc_en && !restart && (cnt_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (restart) begin
          cnt_q <= '0;
        end else if (run && osc_en) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cur_time,
  output rtc_time_t next_time
);
  rtc_time_t time_q;

  assign cur_time  = time_q;
  assign next_time = advance_second(time_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= TIME_AT_RESET;
    end else if (load) begin
      time_q <= load_val;
    end else if (tick) begin
      time_q <= next_time;
    end
  end
endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port
  import rtc_pkg::*;
#(
  parameter int RECOVER_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pwr_fail,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wprot
);
  localparam int RW = $clog2(RECOVER_CYCLES + 1);
  localparam logic [RW-1:0] RLOAD = RW'(RECOVER_CYCLES);

  logic              active;
  logic              act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [RW-1:0]     rec_q;

  assign active    = !cs_n && !we_n;
  assign wr_strobe = act_q && !active;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign wprot     = pwr_fail || (rec_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= active;
      if (active) begin
        addr_q <= addr;
        data_q <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (pwr_fail) begin
      rec_q <= RLOAD;
    end else if (rec_q != '0) begin
      rec_q <= rec_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_pkg::*;
#(
  parameter int PRESCALE_DIV   = 32768,
  parameter int RECOVER_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              pwr_fail,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  rtc_time_t         user_time;
  rtc_time_t         cur_time;
  rtc_time_t         next_time;
  logic              freeze_q;
  logic              keep_q;
  logic              dirty_q;
  logic              wr_strobe;
  logic              wr_ok;
  logic              wprot;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              ctrl_wr;
  logic              time_wr;
  logic              load;
  logic              run;
  logic              sec_tick;
  logic              refresh;
  logic [DATA_W-1:0] ctrl_byte;
  logic [DATA_W-1:0] rd_byte;

  rtc_bus_port #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .addr     (addr),
    .wdata    (wdata),
    .pwr_fail (pwr_fail),
    .wr_strobe(wr_strobe),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wprot    (wprot)
  );

  assign wr_ok   = wr_strobe && !wprot;
  assign ctrl_wr = wr_ok && (wr_addr == ADDR_CTRL);
  assign time_wr = wr_ok && freeze_q && (wr_addr <= ADDR_CEN);
  assign load    = ctrl_wr && freeze_q && !wr_data[CTRL_FREEZE_BIT] && dirty_q;
  assign run     = !pwr_fail || keep_q;
  assign refresh = sec_tick && !freeze_q;

  rtc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .run    (run),
    .restart(load),
    .tick   (sec_tick)
  );

  rtc_time_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .load     (load),
    .load_val (user_time),
    .cur_time (cur_time),
    .next_time(next_time)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      keep_q   <= 1'b0;
      dirty_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        freeze_q <= wr_data[CTRL_FREEZE_BIT];
        keep_q   <= wr_data[CTRL_KEEP_BIT];
        if (!wr_data[CTRL_FREEZE_BIT]) dirty_q <= 1'b0;
      end else if (time_wr) begin
        dirty_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_time <= TIME_AT_RESET;
    end else if (refresh) begin
      user_time <= next_time;
    end else if (time_wr) begin
      user_time <= field_put(user_time, wr_addr, wr_data);
    end
  end

  always_comb begin
    ctrl_byte = '0;
    ctrl_byte[CTRL_KEEP_BIT]   = keep_q;
    ctrl_byte[CTRL_FREEZE_BIT] = freeze_q;
  end

  always_comb begin
    if (addr <= ADDR_CEN)       rd_byte = field_get(user_time, addr);
    else if (addr == ADDR_CTRL) rd_byte = ctrl_byte;
    else                        rd_byte = '0;
  end

  assign rdata_oe = !cs_n && !oe_n && we_n;
  assign rdata    = rdata_oe ? rd_byte : '0;
endmodule

// File: rtl/rtc_shadow_checker.sv
module rtc_shadow_checker
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sec_tick,
  input logic      load,
  input logic      freeze_q,
  input logic      keep_q,
  input logic      pwr_fail,
  input logic      wr_ok,
  input logic      wr_strobe,
  input logic      wprot,
  input logic [7:0] ctrl_byte,
  input rtc_time_t cur_time,
  input rtc_time_t user_time,
  input logic [7:0] rdata,
  input logic      rdata_oe
);
  p_tick_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !load |=> cur_time != $past(cur_time));

  p_refresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !freeze_q |=> user_time == cur_time);

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !load && cur_time.sec == 8'h59 |=> cur_time.sec == 8'h00);

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_q && !wr_ok |=> $stable(user_time));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_time == $past(user_time));

  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == 8'h00);

  p_keep_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail && !keep_q |-> !sec_tick);

  p_locked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wprot && wr_strobe |=> $stable(ctrl_byte));

  p_recover_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_fail) |-> wprot);
endmodule

bind rtc_shadow_regs rtc_shadow_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .load     (load),
  .freeze_q (freeze_q),
  .keep_q   (keep_q),
  .pwr_fail (pwr_fail),
  .wr_ok    (wr_ok),
  .wr_strobe(wr_strobe),
  .wprot    (wprot),
  .ctrl_byte(ctrl_byte),
  .cur_time (cur_time),
  .user_time(user_time),
  .rdata    (rdata),
  .rdata_oe (rdata_oe)
);

// File: tb/tb_rtc_shadow_regs.sv
module tb_rtc_shadow_regs;
  localparam int DIV = 64;
  localparam int REC = 8;
  localparam int NVEC = 8;

  // {start, expected after one tick}; each half is {cen,yr,mon,day,hr,min,sec}
  localparam logic [111:0] VEC [0:NVEC-1] = '{
    {56'h20_00_01_01_00_00_00, 56'h20_00_01_01_00_00_01},
    {56'h19_99_12_31_23_59_59, 56'h20_00_01_01_00_00_00},
    {56'h20_24_02_28_23_59_59, 56'h20_24_02_29_00_00_00},
    {56'h20_23_02_28_23_59_59, 56'h20_23_03_01_00_00_00},
    {56'h20_05_04_30_23_59_59, 56'h20_05_05_01_00_00_00},
    {56'h20_10_06_15_12_59_59, 56'h20_10_06_15_13_00_00},
    {56'h20_96_02_29_23_59_59, 56'h20_96_03_01_00_00_00},
    {56'h20_41_01_31_09_09_09, 56'h20_41_01_31_09_09_10}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b1;
  logic       pwr_fail = 1'b0;
  logic       cs_n = 1'b1;
  logic       we_n = 1'b1;
  logic       oe_n = 1'b1;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rdata_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] rd;
  logic [7:0] s0;

  always #2 clk = ~clk;

  rtc_shadow_regs #(.PRESCALE_DIV(DIV), .RECOVER_CYCLES(REC)) dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .pwr_fail(pwr_fail),
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; addr = a;
    #1 d = rdata;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  // own BCD second step: binary round trip modulo 60
  function automatic logic [7:0] sec_plus(input logic [7:0] s, input int n);
    int v;
    v = (s[7:4] * 10 + s[3:0] + n) % 60;
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic set_time(input logic [55:0] t);
    bus_write(4'hE, 8'h08);
    for (int i = 0; i < 7; i++) bus_write(4'(i), t[8*i +: 8]);
    bus_write(4'hE, 8'h00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    for (int i = 0; i < 7; i++) begin
      bus_read(4'(i), rd);
      check($sformatf("R1 reg%0d", i), rd, 8'(56'h20_00_01_01_00_00_00 >> (8*i)));
    end
    bus_read(4'hE, rd); check("R1 ctrl", rd, 8'h00);

    // R10: idle bus and unused address
    @(negedge clk); #1 check("R10 idle rdata", rdata, 8'h00);
    check("R10 idle oe", {7'd0, rdata_oe}, 8'h00);
    bus_read(4'h9, rd); check("R10 unused", rd, 8'h00);

    // Vector table: R2 R3 R4 R8
    for (int v = 0; v < NVEC; v++) begin
      set_time(VEC[v][111:56]);
      repeat (DIV - 4) @(negedge clk);
      bus_read(4'h0, rd);
      check($sformatf("R8 no early tick v%0d", v), rd, VEC[v][63:56]);
      repeat (4) @(negedge clk);
      for (int i = 0; i < 7; i++) begin
        bus_read(4'(i), rd);
        check($sformatf("R2/R3/R4 v%0d reg%0d", v, i), rd, VEC[v][8*i +: 8]);
      end
    end

    // R9: time write ignored while freeze bit is clear
    set_time(56'h20_30_07_04_10_20_10);
    repeat (DIV / 2) @(negedge clk);
    bus_write(4'h0, 8'h42);
    bus_read(4'h0, rd); check("R9 ignored write", rd, 8'h10);

    // R6/R5/R7: freeze lands on the tick edge
    set_time(56'h20_30_07_04_10_20_10);
    repeat (DIV - 3) @(negedge clk);
    bus_write(4'hE, 8'h08);
    bus_read(4'h0, rd); check("R6 refresh kept", rd, 8'h11);
    bus_read(4'hE, rd); check("R5 freeze bit", rd, 8'h08);
    repeat (DIV / 2 + 3 * DIV) @(negedge clk);
    bus_read(4'h0, rd); check("R5 held", rd, 8'h11);
    bus_write(4'hE, 8'h00);
    bus_read(4'h0, rd); check("R7 no transfer", rd, 8'h11);
    repeat (DIV) @(negedge clk);
    bus_read(4'h0, rd); check("R7 catch up", rd, 8'h15);

    // R11: first rising strobe closes the write
    bus_write(4'hE, 8'h08);
    @(negedge clk); cs_n = 1'b0; we_n = 1'b0; addr = 4'h0; wdata = 8'h33;
    @(negedge clk); cs_n = 1'b1; wdata = 8'h44;
    @(negedge clk); we_n = 1'b1;
    bus_read(4'h0, rd); check("R11 cs_n first", rd, 8'h33);
    @(negedge clk); cs_n = 1'b0; we_n = 1'b0; addr = 4'h1; wdata = 8'h21;
    @(negedge clk); we_n = 1'b1; wdata = 8'h47;
    @(negedge clk); cs_n = 1'b1;
    bus_read(4'h1, rd); check("R11 we_n first", rd, 8'h21);
    bus_write(4'hE, 8'h00);

    // R12/R13: supply failure with keep-alive clear
    bus_read(4'h0, s0);
    @(negedge clk); pwr_fail = 1'b1;
    bus_write(4'hE, 8'h88);
    bus_read(4'hE, rd); check("R13 locked", rd, 8'h00);
    bus_read(4'h0, s0);
    repeat (3 * DIV) @(negedge clk);
    bus_read(4'h0, rd); check("R12 stopped", rd, s0);
    @(negedge clk); pwr_fail = 1'b0;
    bus_write(4'hE, 8'h80);
    bus_read(4'hE, rd); check("R13 recovery lock", rd, 8'h00);
    repeat (REC + 2) @(negedge clk);
    bus_write(4'hE, 8'h80);
    bus_read(4'hE, rd); check("R13 unlocked", rd, 8'h80);

    // R12: keep-alive set keeps the clock running on battery
    @(negedge clk); pwr_fail = 1'b1;
    bus_read(4'h0, s0);
    repeat (2 * DIV - 1) @(negedge clk);
    bus_read(4'h0, rd); check("R12 running", rd, sec_plus(s0, 2));
    @(negedge clk); pwr_fail = 1'b0;
    repeat (REC + 2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule